// File: doc/BRIEF.md
# Encoded Interrupt Vector and Two-Byte Data Port

This block sits between a register bus and the bit-level engine of an I2C master. The engine raises one-cycle pulses for five kinds of event. The block keeps each event pending until software reads it. Instead of a status bitmask, software sees one small numeric code in a vector register. Reading that register retires the event it returned. An interrupt line stays high while any event is still pending.

The block also provides a 16-bit data register that moves two bytes per access, with the low byte first on the wire. A transfer-length counter sets how many bytes are still to be moved. When only one byte is left, only the low half of the word is used. On the transmit side, a holding register gives bytes to the engine one at a time. On the receive side, bytes from the engine are packed into a word that software collects with one read. A control-register write can request a stop condition at any time, including straight after a no-acknowledge.

Top module: `i2c_legacy_regfront`

## Requirements
- R1: Register address 0 is the vector register. A read returns a code in bits 2:0: 0 = nothing pending, 1 = arbitration lost, 2 = no acknowledge, 3 = register access ready, 4 = receive data ready, 5 = transmit data ready. Input `ev_pulse` bit i raises the event with code i+1.
- R2: When several events are pending, the vector register and `vec_code` report the lowest nonzero code. The other events stay pending and show up on later reads.
- R3: A vector-register read retires only the event whose code it returned. From the next cycle, `vec_code` shows the next pending code, or 0 if none is left.
- R4: An event pulse in the same cycle as a clearing vector read is kept pending. This holds whether its code is a different one or the one being retired.
- R5: `irq` is high exactly when at least one event is pending.
- R6: A write to the data register (address 1) is accepted when the transmit holding register is empty and the remaining count is at least 2. It then loads two bytes and lowers the count by 2. `tx_byte` shows the low byte first, and after one `tx_take` it shows the high byte.
- R7: With a remaining count of 1, a data-register write loads only the low byte and the count becomes 0. A write is ignored when the count is 0 or the holding register still has bytes.
- R8: Each accepted `rx_push` lowers the count by 1. The first byte lands in bits 7:0 of the receive word and the second in bits 15:8. A data-register read returns the word, with unfilled bytes reading 0, and empties it. A push is dropped when the count is 0 or two bytes are already held. A data-register write in the same cycle is served from the count first.
- R9: Address 2 holds the remaining count. A write loads `reg_wdata[CNT_W-1:0]` and takes priority over any decrement. A read returns the count. `reg_rdata` is 0 whenever `reg_rd` is low.
- R10: A write to address 3 with bit 1 set raises `stop_req` for exactly the next cycle, whatever events are pending. A write with bit 1 clear raises nothing.
- R11: After reset, `irq`, `vec_code`, `tx_avail`, `stop_req` and the count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 5 | Event pulses from the bit engine, bit i = code i+1 |
| reg_addr | input | 2 | Register select: 0 vector, 1 data, 2 count, 3 control |
| reg_rd | input | 1 | Register read strobe (data returned in the same cycle) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, 0 when no read |
| vec_code | output | 3 | Code currently at the head of the vector |
| irq | output | 1 | High while any event is pending |
| tx_avail | output | 1 | Transmit byte is available |
| tx_byte | output | 8 | Next byte to send |
| tx_take | input | 1 | Engine consumes `tx_byte` |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| stop_req | output | 1 | One-cycle stop request to the engine |

## Verification
The bench builds the block with a 4-bit count. This makes count writes wider than the field truncate, and it lets a few short transfers reach both the one-byte-left case and the count-of-zero case. The count is set directly through its register, so the single-byte and exhausted-count paths in both directions can be reached without long transfers. Vector ordering is exercised with several codes pending at once and with event pulses that coincide with clearing reads.

// File: rtl/i2c_lv_pkg.sv
package i2c_lv_pkg;
  localparam int NUM_EV   = 5;
  localparam int CODE_W   = 3;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int STOP_BIT = 1;

  localparam logic [1:0] ADDR_VEC  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  // lowest pending code, 0 when nothing pending
  function automatic logic [CODE_W-1:0] lowest_code(input logic [NUM_EV-1:0] p);
    lowest_code = '0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (p[i]) lowest_code = CODE_W'(i + 1);
    end
  endfunction

  // one-hot pending bit for a code, empty for code 0
  function automatic logic [NUM_EV-1:0] code_mask(input logic [CODE_W-1:0] c);
    code_mask = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (c == CODE_W'(i + 1)) code_mask[i] = 1'b1;
    end
  endfunction
endpackage

// File: rtl/lv_vector_unit.sv
module lv_vector_unit
  import i2c_lv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic              clr_rd,
  output logic [CODE_W-1:0] code,
  output logic              irq,
  output logic [NUM_EV-1:0] clr_mask
);
  logic [NUM_EV-1:0] pend_q;

  assign code     = lowest_code(pend_q);
  assign irq      = |pend_q;
  assign clr_mask = clr_rd ? code_mask(code) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | ev;
  end

  // R3
  cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~ev)) |=> ((pend_q & $past(clr_mask & ~ev)) == '0));
  // R4
  ev_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((pend_q & $past(ev)) == $past(ev)));
  // R2
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_mask));
  // R2
  others_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> ((pend_q & $past(pend_q & ~clr_mask)) == $past(pend_q & ~clr_mask)));
endmodule

// File: rtl/lv_tx_packer.sv
module lv_tx_packer
  import i2c_lv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        load_n,
  input  logic [WORD_W-1:0] word,
  input  logic              take,
  output logic              tx_avail,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              empty
);
  logic [WORD_W-1:0] hold_q;
  logic [1:0]        hold_n;

  assign tx_avail = (hold_n != 2'd0);
  assign empty    = (hold_n == 2'd0);
  assign tx_byte  = hold_q[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_n <= 2'd0;
    end else if (load) begin
      hold_q <= word;
      hold_n <= load_n;
    end else if (take && hold_n != 2'd0) begin
      hold_q <= {{BYTE_W{1'b0}}, hold_q[WORD_W-1:BYTE_W]};
      hold_n <= hold_n - 2'd1;
    end
  end

  // R6
  hi_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n == 2'd2 && take && !load) |=> (tx_byte == $past(hold_q[WORD_W-1:BYTE_W]) && hold_n == 2'd1));
  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_n <= 2'd2);
endmodule

// File: rtl/lv_rx_packer.sv
module lv_rx_packer
  import i2c_lv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              clear,
  output logic [WORD_W-1:0] word,
  output logic              room
);
  logic [WORD_W-1:0] word_q;
  logic [1:0]        n_q;

  assign word = word_q;
  assign room = (n_q < 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      n_q    <= 2'd0;
    end else if (clear) begin
      word_q <= accept ? {{BYTE_W{1'b0}}, byte_in} : '0;
      n_q    <= accept ? 2'd1 : 2'd0;
    end else if (accept) begin
      if (n_q == 2'd0) word_q[BYTE_W-1:0]      <= byte_in;
      else             word_q[WORD_W-1:BYTE_W] <= byte_in;
      n_q <= n_q + 2'd1;
    end
  end

  // R8
  rx_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q != 2'd2) |-> (word_q[WORD_W-1:BYTE_W] == '0));
  // R8
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= 2'd2);
endmodule

// File: rtl/i2c_legacy_regfront.sv
module i2c_legacy_regfront
  import i2c_lv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_pulse,
  input  logic [1:0]        reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [CODE_W-1:0] vec_code,
  output logic              irq,
  output logic              tx_avail,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_take,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              stop_req
);
  // bytes a data write may take from the remaining count
  function automatic logic [1:0] tx_grant(input logic [CNT_W-1:0] c);
    if (c == '0)                return 2'd0;
    else if (c == CNT_W'(1))    return 2'd1;
    else                        return 2'd2;
  endfunction

  logic vec_rd, data_rd, data_wr, cnt_wr, ctrl_wr;
  logic [NUM_EV-1:0] clr_mask;
  logic tx_empty, tx_load, rx_room, rx_ok;
  logic [1:0] tx_n;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [CNT_W-1:0] cnt_q, cnt_rem, cnt_d;

  assign vec_rd  = reg_rd && (reg_addr == ADDR_VEC);
  assign data_rd = reg_rd && (reg_addr == ADDR_DATA);
  assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
  assign cnt_wr  = reg_wr && (reg_addr == ADDR_CNT);
  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

  lv_vector_unit u_vec (
    .clk(clk), .rst_n(rst_n), .ev(ev_pulse), .clr_rd(vec_rd),
    .code(vec_code), .irq(irq), .clr_mask(clr_mask)
  );

  assign tx_n    = tx_grant(cnt_q);
  assign tx_load = data_wr && tx_empty && (tx_n != 2'd0);
  assign tx_word = (tx_n == 2'd1) ? {{BYTE_W{1'b0}}, reg_wdata[BYTE_W-1:0]} : reg_wdata;

  lv_tx_packer u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_n(tx_n), .word(tx_word),
    .take(tx_take), .tx_avail(tx_avail), .tx_byte(tx_byte), .empty(tx_empty)
  );

  assign cnt_rem = cnt_q - CNT_W'(tx_load ? tx_n : 2'd0);
  assign rx_ok   = rx_push && rx_room && (cnt_rem != '0);
  assign cnt_d   = cnt_wr ? reg_wdata[CNT_W-1:0] : (cnt_rem - CNT_W'(rx_ok));

  lv_rx_packer u_rx (
    .clk(clk), .rst_n(rst_n), .accept(rx_ok), .byte_in(rx_byte),
    .clear(data_rd), .word(rx_word), .room(rx_room)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      stop_req <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      stop_req <= ctrl_wr && reg_wdata[STOP_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        ADDR_VEC:  reg_rdata = WORD_W'(vec_code);
        ADDR_DATA: reg_rdata = rx_word;
        ADDR_CNT:  reg_rdata = WORD_W'(cnt_q);
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R9
  cnt_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q <= $past(cnt_q)));
  // R10
  stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> $past(ctrl_wr && reg_wdata[STOP_BIT]));
  // R7
  single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && data_wr && tx_empty && !cnt_wr) |=> (cnt_q == '0 && tx_avail));
  // R5
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_code != '0));
endmodule

// File: tb/sim_i2c_legacy_regfront.sv
module sim_i2c_legacy_regfront;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] ev_pulse = '0;
  logic [1:0] reg_addr = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0] vec_code;
  logic irq, tx_avail, stop_req;
  logic [7:0] tx_byte;
  logic tx_take = 1'b0, rx_push = 1'b0;
  logic [7:0] rx_byte = '0;

  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_legacy_regfront #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_code(vec_code), .irq(irq), .tx_avail(tx_avail), .tx_byte(tx_byte),
    .tx_take(tx_take), .rx_push(rx_push), .rx_byte(rx_byte), .stop_req(stop_req)
  );

  // behavioural reference model
  bit [4:0] pm;
  logic [7:0] tq[$];
  logic [7:0] rq[$];
  int cnt;
  bit stop_e;

  function automatic int m_code();
    for (int i = 0; i < 5; i++) if (pm[i]) return i + 1;
    return 0;
  endfunction

  function automatic logic [15:0] m_rdata(input logic [1:0] a);
    logic [15:0] w;
    w = '0;
    case (a)
      2'd0: w = 16'(m_code());
      2'd1: begin
        if (rq.size() > 0) w[7:0]  = rq[0];
        if (rq.size() > 1) w[15:8] = rq[1];
      end
      2'd2: w = 16'(cnt);
      default: w = '0;
    endcase
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm = '0; tq.delete(); rq.delete(); cnt = 0; stop_e = 0;
    end else begin
      bit [4:0] clr;
      int pre, txn, rem;
      bit rxok;
      clr = '0;
      if (reg_rd && reg_addr == 2'd0 && pm != 0) clr[m_code() - 1] = 1'b1;
      pre = tq.size();
      if (tx_take && pre > 0) void'(tq.pop_front());
      txn = 0;
      if (reg_wr && reg_addr == 2'd1 && pre == 0 && cnt > 0) begin
        tq.push_back(reg_wdata[7:0]); txn = 1;
        if (cnt >= 2) begin tq.push_back(reg_wdata[15:8]); txn = 2; end
      end
      rem = cnt - txn;
      rxok = rx_push && rq.size() < 2 && rem > 0;
      if (reg_rd && reg_addr == 2'd1) rq.delete();
      if (rxok) rq.push_back(rx_byte);
      cnt = rem - int'(rxok);
      if (reg_wr && reg_addr == 2'd2) cnt = int'(reg_wdata) % (1 << CW);
      stop_e = reg_wr && reg_addr == 2'd3 && reg_wdata[1];
      pm = (pm & ~clr) | ev_pulse;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R1 R2 R3 R5 R6 R10)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] a, e;
      a = {irq, vec_code, tx_avail, stop_req, (tx_avail ? tx_byte : 8'h00)};
      e = {pm != 0, 3'(m_code()), tq.size() > 0, stop_e, (tq.size() > 0 ? tq[0] : 8'h00)};
      check(a == e, "R5 R3 R6 R10 model compare", a, e);
    end
  end

  task automatic op(input logic [1:0] a, input bit rd, input bit wr, input logic [15:0] wd,
                    input logic [4:0] ev, input bit take, input bit push, input logic [7:0] pb,
                    output logic [15:0] rv);
    @(negedge clk); #1;
    reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd; ev_pulse = ev;
    tx_take = take; rx_push = push; rx_byte = pb;
    #1;
    rv = reg_rdata;
    if (rd) check(rv == m_rdata(a), "R9 read data vs model", rv, m_rdata(a));
    else    check(rv == 16'h0, "R9 idle read data", rv, 0);
    @(posedge clk); #1;
    reg_rd = 0; reg_wr = 0; ev_pulse = '0; tx_take = 0; rx_push = 0;
  endtask

  logic [15:0] rv;
  task automatic rd_reg(input logic [1:0] a); op(a, 1, 0, 0, 0, 0, 0, 0, rv); endtask
  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d); op(a, 0, 1, d, 0, 0, 0, 0, rv); endtask
  task automatic pulse(input logic [4:0] e); op(0, 0, 0, 0, e, 0, 0, 0, rv); endtask
  task automatic take1(); op(0, 0, 0, 0, 0, 1, 0, 0, rv); endtask
  task automatic push1(input logic [7:0] b); op(0, 0, 0, 0, 0, 0, 1, b, rv); endtask
  task automatic idle(); op(0, 0, 0, 0, 0, 0, 0, 0, rv); endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    @(negedge clk);
    check({irq, vec_code, tx_avail, stop_req} == 0, "R11 reset outputs", {irq, vec_code, tx_avail, stop_req}, 0);
    rd_reg(2); check(rv == 0, "R11 reset count", rv, 0);

    // R1 each code alone
    for (int i = 0; i < 5; i++) begin
      pulse(5'(1 << i));
      check(irq == 1, "R5 irq with one pending", irq, 1);
      rd_reg(0); check(rv == 16'(i + 1), "R1 single event code", rv, i + 1);
      check(irq == 0, "R5 irq after clear", irq, 0);
    end
    rd_reg(0); check(rv == 0, "R1 empty vector", rv, 0);

    // R2 several pending: codes 2,3,5
    pulse(5'b10110);
    rd_reg(0); check(rv == 2, "R2 first lowest", rv, 2);
    rd_reg(0); check(rv == 3, "R2 second", rv, 3);
    rd_reg(0); check(rv == 5, "R2 third", rv, 5);
    rd_reg(0); check(rv == 0, "R2 drained", rv, 0);

    // R3 vec_code follows clearing reads
    pulse(5'b01001);
    check(vec_code == 1, "R3 head before read", vec_code, 1);
    rd_reg(0); check(rv == 1, "R3 read head", rv, 1);
    check(vec_code == 4, "R3 head after read", vec_code, 4);
    rd_reg(0); check(vec_code == 0, "R3 head empty", vec_code, 0);

    // R4 event arriving with a clearing read
    pulse(5'b00101);
    op(0, 1, 0, 0, 5'b00010, 0, 0, 0, rv); check(rv == 1, "R4 read code 1", rv, 1);
    rd_reg(0); check(rv == 2, "R4 new event kept", rv, 2);
    rd_reg(0); check(rv == 3, "R4 older kept", rv, 3);
    rd_reg(0); check(rv == 0, "R4 drained", rv, 0);
    pulse(5'b01000);
    op(0, 1, 0, 0, 5'b01000, 0, 0, 0, rv); check(rv == 4, "R4 same code read", rv, 4);
    check(irq == 1, "R4 same code stays pending", irq, 1);
    rd_reg(0); check(rv == 4, "R4 same code again", rv, 4);
    check(irq == 0, "R5 irq low when empty", irq, 0);

    // R9 count register
    wr_reg(2, 16'h0005); rd_reg(2); check(rv == 5, "R9 count write", rv, 5);
    wr_reg(2, 16'h00F3); rd_reg(2); check(rv == 3, "R9 count truncated", rv, 3);

    // R6 two-byte transmit, count 3
    wr_reg(1, 16'hB7A1);
    check(tx_avail && tx_byte == 8'hA1, "R6 low byte first", tx_byte, 8'hA1);
    rd_reg(2); check(rv == 1, "R6 count minus two", rv, 1);
    take1(); check(tx_avail && tx_byte == 8'hB7, "R6 high byte second", tx_byte, 8'hB7);
    take1(); check(tx_avail == 0, "R6 holding drained", tx_avail, 0);
    // R7 one byte left
    wr_reg(1, 16'h55C4);
    check(tx_avail && tx_byte == 8'hC4, "R7 single low byte", tx_byte, 8'hC4);
    rd_reg(2); check(rv == 0, "R7 count zero", rv, 0);
    take1(); check(tx_avail == 0, "R7 high byte not sent", tx_avail, 0);
    wr_reg(1, 16'h1234); check(tx_avail == 0, "R7 write at count zero ignored", tx_avail, 0);
    // R7 write while holding busy
    wr_reg(2, 16'h0004);
    wr_reg(1, 16'h1122);
    wr_reg(1, 16'h3344);
    rd_reg(2); check(rv == 2, "R7 busy write ignored count", rv, 2);
    check(tx_byte == 8'h22, "R7 busy write kept bytes", tx_byte, 8'h22);
    take1(); check(tx_byte == 8'h11, "R7 second kept byte", tx_byte, 8'h11);
    take1(); check(tx_avail == 0, "R7 drained", tx_avail, 0);

    // R8 receive packing, count 3
    wr_reg(2, 16'h0003);
    push1(8'h9A); push1(8'h3C);
    rd_reg(1); check(rv == 16'h3C9A, "R8 two bytes packed", rv, 16'h3C9A);
    rd_reg(2); check(rv == 1, "R8 count after two", rv, 1);
    push1(8'h77); push1(8'h88);
    rd_reg(1); check(rv == 16'h0077, "R8 single byte, push at zero dropped", rv, 16'h0077);
    wr_reg(2, 16'h0005);
    push1(8'h01); push1(8'h02); push1(8'h03);
    rd_reg(1); check(rv == 16'h0201, "R8 overflow dropped", rv, 16'h0201);
    rd_reg(2); check(rv == 3, "R8 dropped byte not counted", rv, 3);
    rd_reg(1); check(rv == 0, "R8 word emptied", rv, 0);
    // R8 write and push together: count 2 goes to transmit
    wr_reg(2, 16'h0002);
    op(1, 0, 1, 16'hEEDD, 0, 0, 1, 8'h44, rv);
    rd_reg(1); check(rv == 0, "R8 write served first", rv, 0);
    take1(); take1();

    // R10 stop after no-acknowledge
    pulse(5'b00010);
    wr_reg(3, 16'h0002);
    check(stop_req == 1, "R10 stop raised", stop_req, 1);
    idle(); check(stop_req == 0, "R10 stop one cycle", stop_req, 0);
    wr_reg(3, 16'hFFFD); check(stop_req == 0, "R10 no stop without bit", stop_req, 0);
    rd_reg(0); check(rv == 2, "R10 vector untouched", rv, 2);

    idle();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule